// File: doc/BRIEF.md
# Programmable Countdown Timer with Underflow Flag

The block is a 32-bit general-purpose down-counter that a host programs through four 16-bit word registers. The count is held as a low half and a high half. While the timer runs, a prescaler divides the system clock down to a fixed 5 MHz tick, and each tick takes one from the count. When the count passes below zero it wraps to all ones, raises a sticky completion flag and keeps counting. The flag is both an output pin and a readable status bit.

The host controls the timer with two bits in a command word. Writing the run bit starts the timer and writing the halt bit stops it, and each one cancels the other. A halted count is frozen, so the host can read it back. If the host writes either count word, the count restarts from the new value. A read of the low word also captures the high word, so a following read of the high word gives the same instant even when a borrow ripples between the reads.

Top module: `cd_timer`

## Requirements
- R1: After reset the timer is halted, the command word reads 0x0010, both count words read 0, the status word reads 0 and `tmr_done` is low.
- R2: Writing the command word (addr 0) with bit 5 (0x0020) set starts counting and clears the prescaler. The command word then reads 0x0020.
- R3: Writing the command word with bit 4 (0x0010) set and bit 5 clear halts the timer and freezes the count. Writing both bits together leaves the timer running.
- R4: While the timer runs, the count falls by one on every PRESCALE-th clock edge after the start edge. The edge that applies a halt write still counts.
- R5: A tick at count 0 loads 0xFFFFFFFF, sets the completion flag, and counting goes on from there.
- R6: Writes to addr 1 (low word) or addr 2 (high word) replace that half of the count. A write while running clears the prescaler and overrides a tick in the same cycle. A write while halted leaves the timer halted.
- R7: A read of addr 1 returns the live low word and captures the high word. A read of addr 2 returns the word captured by the most recent low-word read.
- R8: The status word (addr 3) shows the completion flag at bit 7 (0x0080). Writing 1 to bit 7 clears the flag, writing 0 leaves it, and an underflow in the same cycle wins over the clear.
- R9: A halted timer never ticks and never underflows, however long it waits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe (captures the high word on a low-word read) |
| addr | input | 2 | Word select: 0 command, 1 count low, 2 count high, 3 status |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Read data for the selected word |
| tmr_done | output | 1 | Sticky completion (underflow) flag |

## Verification
A prescaler phase that is off by even one cycle moves every later decrement. The error then shows in the frozen count read back after the halt write, within one prescaler period of the start. A wrong run/halt state shows on the command word at once, and as a count that drifts while it should be frozen. A broken capture register shows as a high word that follows the live count when it should hold the value from the low-word read, and this can be seen in the first read pair that straddles a borrow.

// File: rtl/cd_timer.sv
`timescale 1ns/1ps
module cd_timer #(
  parameter int PRESCALE = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        tmr_done
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

  logic          stopped;
  logic [31:0]   count;
  logic [15:0]   hi_snap;
  logic [PW-1:0] pre;

  wire cmd_wr = wr_en && addr == 2'd0;
  wire lo_wr  = wr_en && addr == 2'd1;
  wire hi_wr  = wr_en && addr == 2'd2;
  wire st_wr  = wr_en && addr == 2'd3;
  wire go     = cmd_wr && wdata[5];
  wire halt   = cmd_wr && wdata[4] && !wdata[5];
  wire tick   = !stopped && pre == PMAX;
  wire load   = lo_wr || hi_wr;
  wire under  = tick && !load && count == 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)     stopped <= 1'b1;
    else if (go)    stopped <= 1'b0;
    else if (halt)  stopped <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go || load || stopped || tick) pre <= '0;
    else                                         pre <= pre + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (load) begin
      if (lo_wr) count[15:0]  <= wdata;
      if (hi_wr) count[31:16] <= wdata;
    end else if (tick) count <= count - 32'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 tmr_done <= 1'b0;
    else if (under)             tmr_done <= 1'b1;
    else if (st_wr && wdata[7]) tmr_done <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     hi_snap <= '0;
    else if (rd_en && addr == 2'd1) hi_snap <= count[31:16];
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {10'd0, !stopped, stopped, 4'd0};
      2'd1:    rdata = count[15:0];
      2'd2:    rdata = hi_snap;
      default: rdata = {8'd0, tmr_done, 7'd0};
    endcase
  end
endmodule

// File: rtl/cd_timer_chk.sv
`timescale 1ns/1ps
module cd_timer_chk #(
  parameter int PRESCALE = 25,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    addr,
  input logic [15:0]   wdata,
  input logic          stopped,
  input logic [31:0]   count,
  input logic [PW-1:0] pre,
  input logic          tmr_done
);
  wire cnt_wr = wr_en && (addr == 2'd1 || addr == 2'd2);
  wire tk     = !stopped && pre == PW'(PRESCALE - 1);

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && wdata[5] |=> !stopped && pre == '0);

  assert_halt_stops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd0 && wdata[4] && !wdata[5] |=> stopped);

  assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tk && !cnt_wr && count != 32'd0 |=> count == $past(count) - 32'd1);

  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tk && !cnt_wr && count == 32'd0 |=> count == 32'hFFFF_FFFF && tmr_done);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done && !(wr_en && addr == 2'd3 && wdata[7]) |=> tmr_done);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped && !cnt_wr |=> count == $past(count));

  assert_prescale_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= PW'(PRESCALE - 1));
endmodule

bind cd_timer cd_timer_chk #(.PRESCALE(PRESCALE), .PW(PW)) chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .stopped(stopped), .count(count), .pre(pre), .tmr_done(tmr_done));

// File: tb/cd_timer_test.sv
`timescale 1ns/1ps
module cd_timer_test;
  localparam int P = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        tmr_done;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  cd_timer #(.PRESCALE(P)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_done(tmr_done));

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_count(output logic [31:0] v);
    logic [15:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    v = {hi, lo};
  endtask

  task automatic load(input logic [31:0] c);
    wr(2'd1, c[15:0]);
    wr(2'd2, c[31:16]);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] c;
    logic [31:0] seeds [5];
    seeds[0] = 32'd0; seeds[1] = 32'd1; seeds[2] = 32'd2;
    seeds[3] = 32'd7; seeds[4] = 32'h0001_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 cmd", {16'd0, v}, 32'h10);
    rd_count(c); check("R1 count", c, 32'd0);
    rd(2'd3, v); check("R1 status", {16'd0, v}, 32'd0);
    check("R1 pin", {31'd0, tmr_done}, 32'd0);

    // R4/R5 sweep: seed x run length
    foreach (seeds[si]) begin
      for (int k = 0; k < 12; k++) begin
        logic [31:0] exp;
        logic        fexp;
        int t;
        wr(2'd0, 16'h0010);
        wr(2'd3, 16'h0080);
        load(seeds[si]);
        wr(2'd0, 16'h0020);
        repeat (k) @(negedge clk);
        wr(2'd0, 16'h0010);
        t = (k + 2) / P;
        if (t <= seeds[si]) begin
          exp = seeds[si] - t; fexp = 1'b0;
        end else begin
          exp = 32'hFFFF_FFFF - (t - seeds[si] - 1); fexp = 1'b1;
        end
        rd_count(c);
        check(t > seeds[si] ? "R5 wrapped count" : "R4 count", c, exp);
        check("R5 flag", {31'd0, tmr_done}, {31'd0, fexp});
      end
    end

    // R8 status word and write-1-to-clear
    wr(2'd0, 16'h0010);
    load(32'd0);
    wr(2'd0, 16'h0020);
    repeat (4) @(negedge clk);
    wr(2'd0, 16'h0010);
    rd(2'd3, v); check("R8 status set", {16'd0, v}, 32'h80);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); check("R8 write0 keeps", {16'd0, v}, 32'h80);
    wr(2'd3, 16'h0080);
    rd(2'd3, v); check("R8 write1 clears", {16'd0, v}, 32'h0);
    check("R8 pin", {31'd0, tmr_done}, 32'd0);

    // R3 both bits: run wins; halt alone reads 0x0010
    wr(2'd0, 16'h0030);
    rd(2'd0, v); check("R3 both bits run", {16'd0, v}, 32'h20);
    wr(2'd0, 16'h0010);
    rd(2'd0, v); check("R3 halted", {16'd0, v}, 32'h10);

    // R2 run bit reads back
    load(32'd40);
    wr(2'd0, 16'h0020);
    rd(2'd0, v); check("R2 running", {16'd0, v}, 32'h20);
    wr(2'd0, 16'h0010);

    // R6/R9 write while halted stays halted and frozen
    load(32'd9);
    repeat (20) @(negedge clk);
    rd_count(c); check("R9 frozen", c, 32'd9);
    rd(2'd0, v); check("R6 still halted", {16'd0, v}, 32'h10);

    // R6 write while running clears prescaler
    load(32'd100);
    wr(2'd0, 16'h0020);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd50);
    repeat (2) @(negedge clk);
    wr(2'd0, 16'h0010);
    rd_count(c); check("R6 restart", c, 32'd49);

    // R7 capture across a borrow
    load(32'h0001_0000);
    wr(2'd0, 16'h0020);
    rd(2'd1, v); check("R7 live low", {16'd0, v}, 32'h0);
    repeat (6) @(negedge clk);
    rd(2'd2, v); check("R7 captured high", {16'd0, v}, 32'h1);
    wr(2'd0, 16'h0010);
    rd_count(c); check("R7 fresh pair", c[31:16] == 16'd0 && c[15:0] < 16'hFFFF ? 32'd1 : 32'd0, 32'd1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule